// File: doc/BRIEF.md
# Mailbox-Driven Event Counter Engine

This block is a device-side command processor. A host talks to it through a small byte mailbox. The host writes four outgoing bytes and reads four incoming bytes. The command code goes in outgoing byte 2, and writing that byte starts the command. The engine executes the command one clock later. One clock after that, it copies the code into incoming byte 2 as a completion echo. A host that polls the echo therefore always finds the result bytes already in place.

The engine owns eight up-counters, one for each isolated input line. Each counter has the following:

- a reload value
- a match value
- a count edge, rising or falling
- enable bits for counting, for overflow flagging and for match flagging

The engine also holds an 8-bit relay output register and reports the 8-bit input state. Overflow and match conditions set sticky flag bits, which are brought out as ports. These flags are cleared only by reset.

Top module: `mbox_cnt_engine`

## Requirements
- R1: A write to address 0x0C..0x0F stores outgoing byte 0..3; the outgoing bytes read back as 0x00. A write to 0x0E starts the command. Reads of 0x1C..0x1F return incoming bytes 0..3, and any other read address returns 0x00. The result bytes change one clock after the start write. The echo of the code in incoming byte 2 changes one clock later still.
- R2: Code 0x00 sets incoming byte 2 to 0x00 and puts the synchronized input state in incoming byte 3.
- R3: Code 0x01 loads the relay output from outgoing byte 0. Code 0x02 returns the relay register in incoming byte 0. No other code changes the relay output.
- R4: Code 0x28 loads the count-enable mask from outgoing byte 0, where bit n is counter n. An enabled counter adds one on each selected edge of its input. A disabled counter holds its value.
- R5: Code 0x2C loads the edge mask from outgoing byte 0. A 0 bit counts rising edges and a 1 bit counts falling edges.
- R6: Code 0x29 copies the reload value into each counter whose bit is set in outgoing byte 0. If a count edge arrives in the same cycle, the reload takes priority.
- R7: Code 0x40+n sets the reload value of counter n, and code 0x48+n sets its match value (n = 0..7). The value is {outgoing byte 1, outgoing byte 0}.
- R8: Code 0x2F selects the counter given by bits 2:0 of outgoing byte 0. It returns the counter's low byte in incoming byte 0 and its high byte in incoming byte 1.
- R9: Code 0x2A loads the overflow-enable mask. When an enabled counter wraps from 0xFFFF to 0x0000 and its overflow bit is enabled, ovf_flag bit n sets. The bit stays set until reset.
- R10: Code 0x2B loads the match-enable mask. When counter n equals its match value and its match bit is enabled, match_flag bit n sets. The bit stays set until reset.
- R11: After reset, every match value is 0x8000 and every reload value is 0x0000. All enable masks, edge bits, counters, flags, the relay output and the incoming bytes are 0.
- R12: Any other code is echoed in incoming byte 2 and changes no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 6 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 6 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| din | input | 8 | Asynchronous isolated input lines |
| relay | output | 8 | Relay output register |
| ovf_flag | output | 8 | Sticky overflow flags per counter |
| match_flag | output | 8 | Sticky match flags per counter |

## Verification
A reload command and a counting edge can reach the same counter in the same clock. The bench raises an input line and then times the start write so that the synchronized edge arrives in the execution cycle of a 0x29 command. The reload value is chosen far from the counter's current value plus one, so a count that wrongly wins shows up as a different readback.

The bench also samples between the result update and the echo update. This confirms that incoming byte 0 is already valid while incoming byte 2 still holds the previous code.

// File: rtl/mbox_cnt_engine.sv
module mbox_cnt_engine #(
  parameter int NCNT       = 8,
  parameter int CW         = 16,
  parameter logic [CW-1:0] MATCH_INIT = 16'h8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [5:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [5:0]      rd_addr,
  output logic [7:0]      rd_data,
  input  logic [NCNT-1:0] din,
  output logic [NCNT-1:0] relay,
  output logic [NCNT-1:0] ovf_flag,
  output logic [NCNT-1:0] match_flag
);
  localparam int SW = $clog2(NCNT);

  logic [3:0][7:0] ob, ib;
  logic            go, echo_v;
  logic [7:0]      pend_code;
  logic [NCNT-1:0] en_q, ovf_en, mat_en, edge_sel, reload;
  logic [NCNT-1:0] s1, s2, s3;
  logic [CW-1:0]   cnt [NCNT];
  logic [CW-1:0]   rst_val [NCNT];
  logic [CW-1:0]   mat_val [NCNT];
  wire  [7:0]      cmd = ob[2];
  wire  [SW-1:0]   sel = ob[0][SW-1:0];

  assign rd_data = (rd_addr[5:2] == 4'h7) ? ib[rd_addr[1:0]] : 8'h00;
  assign reload  = (go && cmd == 8'h29) ? ob[0][NCNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob <= '0; go <= 1'b0; s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      if (wr_en && wr_addr[5:2] == 4'h3) ob[wr_addr[1:0]] <= wr_data;
      go <= wr_en && wr_addr == 6'h0E;
      s1 <= din; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib <= '0; echo_v <= 1'b0; pend_code <= '0; relay <= '0;
      en_q <= '0; ovf_en <= '0; mat_en <= '0; edge_sel <= '0;
      for (int k = 0; k < NCNT; k++) begin
        rst_val[k] <= '0;
        mat_val[k] <= MATCH_INIT;
      end
    end else begin
      echo_v <= go;
      if (echo_v) ib[2] <= pend_code;
      if (go) begin
        pend_code <= cmd;
        case (cmd)
          8'h00: ib[3] <= 8'(s2);
          8'h01: relay <= ob[0][NCNT-1:0];
          8'h02: ib[0] <= 8'(relay);
          8'h28: en_q <= ob[0][NCNT-1:0];
          8'h2A: ovf_en <= ob[0][NCNT-1:0];
          8'h2B: mat_en <= ob[0][NCNT-1:0];
          8'h2C: edge_sel <= ob[0][NCNT-1:0];
          8'h2F: begin
            ib[0] <= cnt[sel][7:0];
            ib[1] <= cnt[sel][15:8];
          end
          default: begin
            if (cmd[7:4] == 4'h4 && !cmd[3]) rst_val[cmd[SW-1:0]] <= {ob[1], ob[0]};
            if (cmd[7:4] == 4'h4 &&  cmd[3]) mat_val[cmd[SW-1:0]] <= {ob[1], ob[0]};
          end
        endcase
      end
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [CW-1:0] c;
    logic ov, mt;
    wire pulse = en_q[i] & (edge_sel[i] ? (~s2[i] & s3[i]) : (s2[i] & ~s3[i]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c <= '0; ov <= 1'b0; mt <= 1'b0;
      end else begin
        if (reload[i])  c <= rst_val[i];
        else if (pulse) c <= c + 1'b1;
        if (pulse && !reload[i] && ovf_en[i] && &c) ov <= 1'b1;
        if (mat_en[i] && c == mat_val[i]) mt <= 1'b1;
      end
    end

    assign cnt[i]        = c;
    assign ovf_flag[i]   = ov;
    assign match_flag[i] = mt;
  end
endmodule

// File: rtl/mbox_cnt_engine_chk.sv
module mbox_cnt_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic [7:0] cmd,
  input logic [7:0] echo,
  input logic [7:0] relay,
  input logic [7:0] ovf_flag,
  input logic [7:0] match_flag
);
  p_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ##1 (echo == $past(cmd, 2)));

  p_relay_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(relay) |-> ($past(go) && $past(cmd) == 8'h01));

  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

  p_sticky_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((match_flag & $past(match_flag)) == $past(match_flag)));
endmodule

bind mbox_cnt_engine mbox_cnt_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd), .echo(ib[2]),
  .relay(relay), .ovf_flag(ovf_flag), .match_flag(match_flag)
);

// File: tb/mbox_cnt_engine_tb.sv
module mbox_cnt_engine_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, din = 0;
  logic [7:0] rd_data, relay, ovf_flag, match_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] q_sel[$], q_exp[$];
  string      q_req[$];

  always #4 clk = ~clk;

  mbox_cnt_engine u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .din(din),
    .relay(relay), .ovf_flag(ovf_flag), .match_flag(match_flag));

  // monitor: pops expected items and compares against the ports
  initial forever begin
    logic [7:0] got;
    wait (q_sel.size() != 0);
    if (q_sel[0] < 8'h40) rd_addr = q_sel[0][5:0];
    #1;
    case (q_sel[0])
      8'hF0:   got = relay;
      8'hF1:   got = ovf_flag;
      8'hF2:   got = match_flag;
      default: got = rd_data;
    endcase
    n_chk++;
    if (got !== q_exp[0]) begin
      n_fail++;
      $display("FAIL %s: sel %h got %h expected %h", q_req[0], q_sel[0], got, q_exp[0]);
    end
    void'(q_sel.pop_front()); void'(q_exp.pop_front()); void'(q_req.pop_front());
  end

  task automatic chk(input logic [7:0] sel, input logic [7:0] exp, input string req);
    q_sel.push_back(sel); q_exp.push_back(exp); q_req.push_back(req);
    wait (q_sel.size() == 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic issue(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] code);
    wr(6'h0C, b0); wr(6'h0D, b1); wr(6'h0E, code);
  endtask

  task automatic cmd(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] code,
                     input string req);
    issue(b0, b1, code);
    @(negedge clk); @(negedge clk);
    chk(8'h1E, code, req);
  endtask

  task automatic rd_cnt(input int n, input logic [15:0] exp, input string req);
    cmd(8'(n), 8'h00, 8'h2F, "R8");
    chk(8'h1C, exp[7:0], req);
    chk(8'h1D, exp[15:8], req);
  endtask

  task automatic pulse(input logic [7:0] m);
    din = din | m;  repeat (4) @(negedge clk);
    din = din & ~m; repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(8'hF0, 8'h00, "R11"); chk(8'hF1, 8'h00, "R11"); chk(8'hF2, 8'h00, "R11");
    chk(8'h1E, 8'h00, "R11"); chk(8'h1C, 8'h00, "R11");
    // R1 outgoing bytes are write-only, other addresses read zero
    wr(6'h0F, 8'h5A);
    chk(8'h0F, 8'h00, "R1"); chk(8'h2E, 8'h00, "R1");
    // R3 relay load
    cmd(8'hA5, 8'h00, 8'h01, "R3");
    chk(8'hF0, 8'hA5, "R3");
    // R2 clear and input snapshot
    din = 8'h3C; repeat (4) @(negedge clk);
    cmd(8'h00, 8'h00, 8'h00, "R2");
    chk(8'h1F, 8'h3C, "R2");
    din = 8'h00; repeat (4) @(negedge clk);
    // R1 result before echo
    issue(8'h00, 8'h00, 8'h02);
    @(negedge clk);
    chk(8'h1E, 8'h00, "R1"); chk(8'h1C, 8'hA5, "R1");
    @(negedge clk);
    chk(8'h1E, 8'h02, "R1");
    // R12 unknown code
    cmd(8'hFF, 8'hFF, 8'h77, "R12");
    chk(8'hF0, 8'hA5, "R12");
    pulse(8'hFF);
    rd_cnt(0, 16'h0000, "R12");
    // R11 counting disabled by default
    rd_cnt(7, 16'h0000, "R11");
    // R4/R5 enable and edge select
    cmd(8'h09, 8'h00, 8'h28, "R4");
    cmd(8'h08, 8'h00, 8'h2C, "R5");
    din = 8'h0B; repeat (4) @(negedge clk);
    rd_cnt(0, 16'h0001, "R4"); rd_cnt(3, 16'h0000, "R5");
    din = 8'h00; repeat (4) @(negedge clk);
    rd_cnt(0, 16'h0001, "R4"); rd_cnt(3, 16'h0001, "R5"); rd_cnt(1, 16'h0000, "R4");
    // R7/R6 reload
    cmd(8'h34, 8'h12, 8'h40, "R7");
    cmd(8'h01, 8'h00, 8'h29, "R6");
    rd_cnt(0, 16'h1234, "R6"); rd_cnt(3, 16'h0001, "R6");
    // R6 reload vs simultaneous count edge
    cmd(8'h00, 8'h01, 8'h40, "R7");
    wr(6'h0C, 8'h01);
    @(negedge clk); din = 8'h01;
    wr(6'h0E, 8'h29);
    repeat (3) @(negedge clk);
    rd_cnt(0, 16'h0100, "R6");
    din = 8'h00; repeat (4) @(negedge clk);
    // R9 overflow
    cmd(8'hFF, 8'hFF, 8'h41, "R7");
    cmd(8'h02, 8'h00, 8'h29, "R6");
    cmd(8'h02, 8'h00, 8'h2A, "R9");
    cmd(8'h0B, 8'h00, 8'h28, "R4");
    chk(8'hF1, 8'h00, "R9");
    pulse(8'h02);
    chk(8'hF1, 8'h02, "R9");
    rd_cnt(1, 16'h0000, "R9");
    cmd(8'h00, 8'h00, 8'h2A, "R9");
    chk(8'hF1, 8'h02, "R9");
    // R10 match, including default match value 0x8000
    cmd(8'h03, 8'h00, 8'h4A, "R7");
    cmd(8'hFF, 8'h7F, 8'h44, "R7");
    cmd(8'h10, 8'h00, 8'h29, "R6");
    cmd(8'h14, 8'h00, 8'h2B, "R10");
    cmd(8'h14, 8'h00, 8'h28, "R4");
    chk(8'hF2, 8'h00, "R10");
    pulse(8'h14);
    chk(8'hF2, 8'h10, "R10");
    pulse(8'h14);
    chk(8'hF2, 8'h10, "R10");
    pulse(8'h14);
    chk(8'hF2, 8'h14, "R10");
    rd_cnt(2, 16'h0003, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule